// File: doc/BRIEF.md
# Bit-Serial Configuration Register Loader

This block holds four 12-bit tuning parameters for a receiver lock detector: an integrate step, a decay step, a lock threshold and an unlock threshold. Software cannot write a whole parameter at once. It writes one 8-bit command byte per bus write, and each byte carries one data bit, the bit position, the target register and a commit strobe.

A bit is loaded in two writes. The first write sends the command with the strobe clear. The second write sends the same command with the strobe set. The bit is updated only when the strobe goes from clear to set between two accepted writes. The bit position counts from the most-significant end. Loading a full parameter therefore takes twelve pairs of writes, sent most-significant bit first.

All four parameters are exported in parallel. Register 0 is also driven onto a separate observation port. The last accepted command byte can be read back for diagnostics.

Top module: `cfg_serial_loader`

## Requirements
- R1: When `rst` is high at a rising clock edge, all four parameter registers and the command readback become zero on that edge.
- R2: The command byte fields are as follows. Bit 7 is the commit strobe and bit 6 is the data bit. Bits 5:4 select the register: 0 is integrate, 1 is decay, 2 is lock threshold and 3 is unlock threshold. Bits 3:0 are the bit index. A commit changes only the selected register.
- R3: Bit index k, for k from 0 to 11, writes the data bit into register bit 11-k. No other bit of any register changes.
- R4: An accepted write updates a register only when its strobe is 1 and the strobe of the previous accepted write was 0. After reset, the previous strobe counts as 0. A write with the strobe clear never updates a register. A strobe-set write that follows another strobe-set write does not update a register, even if its data or index differ.
- R5: A commit with bit index 12, 13, 14 or 15 changes no register.
- R6: `cmd_readback` equals the byte of the most recent accepted write. It updates on the clock edge that accepts the write.
- R7: A commit that a write causes on clock edge t appears on the parameter outputs after edge t+1 and not before.
- R8: `obs_out` always equals the integrate register. After the value 0x00A is loaded into register 0, it reads 0x00A.
- R9: A cycle with `wr_en` low does not change the readback or any register, whatever `wr_byte` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Accepts `wr_byte` on this edge |
| wr_byte | input | 8 | Command byte: strobe, data, select, index |
| integ_step | output | 12 | Register 0, integrate step |
| decay_step | output | 12 | Register 1, decay step |
| lock_thresh | output | 12 | Register 2, lock threshold |
| unlock_thresh | output | 12 | Register 3, unlock threshold |
| obs_out | output | 12 | Observation copy of register 0 |
| cmd_readback | output | 8 | Last accepted command byte |

## Verification
On every cycle, the assertions check the following: the reset values, that readback follows accepted writes, that registers stay stable without a commit, that a commit flips at most one bit, and that out-of-range indices and repeated set strobes leave every register untouched. They also check that an idle bus changes nothing. Only the bench scenarios can show the rest. These are the full most-significant-first loading of complete values into each register, the exact bit position that a given index reaches, and the two-cycle latency seen at the outputs.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;

  // Roles of the four parameter registers, by select value.
  typedef enum logic [1:0] {
    ROLE_INTEG  = 2'd0,
    ROLE_DECAY  = 2'd1,
    ROLE_LOCK   = 2'd2,
    ROLE_UNLOCK = 2'd3
  } param_role_e;

  localparam int NUM_PARAMS = 4;

endpackage

// File: rtl/cfg_cmd_capture.sv
// Holds the last accepted command byte and produces a one-cycle commit
// pulse when an accepted write raises the strobe.
module cfg_cmd_capture #(
  parameter int SEL_W = 2,
  parameter int IDX_W = 4,
  localparam int CMD_W = 2 + SEL_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_byte,
  output logic [CMD_W-1:0] cmd_q,
  output logic             commit_q
);

  localparam int STB_BIT = CMD_W - 1;

  logic strobe_rise;

  // R4: the edge is measured against the previously accepted byte.
  always_comb begin
    strobe_rise = wr_en && wr_byte[STB_BIT] && !cmd_q[STB_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q    <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= strobe_rise;
      if (wr_en) begin
        cmd_q <= wr_byte;
      end
    end
  end

endmodule

// File: rtl/cfg_param_reg.sv
// One parameter register. A commit addressed to it writes one bit.
// Index 0 is the most-significant bit.
module cfg_param_reg #(
  parameter int          REG_W  = 12,
  parameter int          SEL_W  = 2,
  parameter int          IDX_W  = 4,
  parameter logic [SEL_W-1:0] MY_SEL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [SEL_W-1:0] sel,
  input  logic [IDX_W-1:0] idx,
  input  logic             data,
  output logic [REG_W-1:0] value
);

  logic             mine;
  logic [REG_W-1:0] hit;

  always_comb begin
    mine = commit && (sel == MY_SEL);
  end

  // R3/R5: bit b answers only to index REG_W-1-b. Indices past the
  // register width match no bit.
  for (genvar b = 0; b < REG_W; b++) begin : g_hit
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(REG_W - 1 - b);
    always_comb begin
      hit[b] = mine && (idx == MY_IDX);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else begin
      for (int b = 0; b < REG_W; b++) begin
        if (hit[b]) begin
          value[b] <= data;
        end
      end
    end
  end

endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int REG_W = 12,
  parameter int IDX_W = 4,
  localparam int SEL_W = 2,
  localparam int CMD_W = 2 + SEL_W + IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CMD_W-1:0] wr_byte,
  output logic [REG_W-1:0] integ_step,
  output logic [REG_W-1:0] decay_step,
  output logic [REG_W-1:0] lock_thresh,
  output logic [REG_W-1:0] unlock_thresh,
  output logic [REG_W-1:0] obs_out,
  output logic [CMD_W-1:0] cmd_readback
);

  import cfg_loader_pkg::*;

  localparam int DATA_BIT = CMD_W - 2;

  logic                   commit_q;
  logic [CMD_W-1:0]       cmd_q;
  logic [REG_W-1:0]       regs [NUM_PARAMS];

  cfg_cmd_capture #(
    .SEL_W (SEL_W),
    .IDX_W (IDX_W)
  ) i_capture (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_byte  (wr_byte),
    .cmd_q    (cmd_q),
    .commit_q (commit_q)
  );

  // The registered command supplies the fields for the commit it caused.
  for (genvar r = 0; r < NUM_PARAMS; r++) begin : g_param
    cfg_param_reg #(
      .REG_W  (REG_W),
      .SEL_W  (SEL_W),
      .IDX_W  (IDX_W),
      .MY_SEL (SEL_W'(r))
    ) i_reg (
      .clk    (clk),
      .rst    (rst),
      .commit (commit_q),
      .sel    (cmd_q[IDX_W +: SEL_W]),
      .idx    (cmd_q[IDX_W-1:0]),
      .data   (cmd_q[DATA_BIT]),
      .value  (regs[r])
    );
  end

  assign integ_step    = regs[ROLE_INTEG];
  assign decay_step    = regs[ROLE_DECAY];
  assign lock_thresh   = regs[ROLE_LOCK];
  assign unlock_thresh = regs[ROLE_UNLOCK];
  assign obs_out       = regs[ROLE_INTEG];
  assign cmd_readback  = cmd_q;

endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk #(
  parameter int REG_W = 12,
  parameter int CMD_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [CMD_W-1:0] wr_byte,
  input logic [REG_W-1:0] integ_step,
  input logic [REG_W-1:0] decay_step,
  input logic [REG_W-1:0] lock_thresh,
  input logic [REG_W-1:0] unlock_thresh,
  input logic [CMD_W-1:0] cmd_readback,
  input logic             commit_q
);

  localparam int IDX_W = CMD_W - 4;

  logic [4*REG_W-1:0] all_regs;
  assign all_regs = {unlock_thresh, lock_thresh, decay_step, integ_step};

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (all_regs == '0) && (cmd_readback == '0));

  a_r6_readback: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cmd_readback == $past(wr_byte));

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cmd_readback));

  a_r4_no_commit_stable: assert property (@(posedge clk) disable iff (rst)
    !commit_q |=> $stable(all_regs));

  a_r3_single_bit: assert property (@(posedge clk) disable iff (rst)
    commit_q |=> $countones(all_regs ^ $past(all_regs)) <= 1);

  a_r4_held_strobe: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_byte[CMD_W-1] && cmd_readback[CMD_W-1]) |=> ##1 $stable(all_regs));

  a_r5_high_index: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (int'(wr_byte[IDX_W-1:0]) >= REG_W)) |=> ##1 $stable(all_regs));

endmodule

bind cfg_serial_loader cfg_serial_loader_chk #(
  .REG_W (REG_W),
  .CMD_W (CMD_W)
) i_chk (
  .clk           (clk),
  .rst           (rst),
  .wr_en         (wr_en),
  .wr_byte       (wr_byte),
  .integ_step    (integ_step),
  .decay_step    (decay_step),
  .lock_thresh   (lock_thresh),
  .unlock_thresh (unlock_thresh),
  .cmd_readback  (cmd_readback),
  .commit_q      (commit_q)
);

// File: tb/test_cfg_serial_loader.sv
module test_cfg_serial_loader;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_byte = '0;
  logic [11:0] integ_step, decay_step, lock_thresh, unlock_thresh, obs_out;
  logic [7:0]  cmd_readback;

  int n_checks = 0;
  int n_fail   = 0;
  logic [11:0] model [4];

  always #4 clk = ~clk;  // 125 MHz

  cfg_serial_loader i_cfg_serial_loader (
    .clk           (clk),
    .rst           (rst),
    .wr_en         (wr_en),
    .wr_byte       (wr_byte),
    .integ_step    (integ_step),
    .decay_step    (decay_step),
    .lock_thresh   (lock_thresh),
    .unlock_thresh (unlock_thresh),
    .obs_out       (obs_out),
    .cmd_readback  (cmd_readback)
  );

  // {select[1:0], value[11:0]}
  localparam logic [13:0] VECS [6] = '{
    {2'd0, 12'h00A}, {2'd1, 12'h001}, {2'd2, 12'h004},
    {2'd3, 12'h006}, {2'd2, 12'hA5C}, {2'd1, 12'hFFF}
  };

  function automatic logic [11:0] out_of(input int r);
    case (r)
      0: return integ_step;
      1: return decay_step;
      2: return lock_thresh;
      default: return unlock_thresh;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < 4; r++) check(req, 32'(out_of(r)), 32'(model[r]));
    check(req, 32'(obs_out), 32'(model[0]));
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1;
    wr_byte = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic [7:0] cmd(input logic s, input logic d, input int r, input int k);
    return {s, d, 2'(r), 4'(k)};
  endfunction

  // Loads a value most-significant bit first, index 0 carrying bit 11.
  task automatic load(input int r, input logic [11:0] v);
    for (int k = 0; k < 12; k++) begin
      wr(cmd(1'b0, v[11-k], r, k));
      wr(cmd(1'b1, v[11-k], r, k));
    end
    tick();
    model[r] = v;
  endtask

  initial begin
    for (int r = 0; r < 4; r++) model[r] = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset state
    check_all("R1 reset");
    check("R1 readback", 32'(cmd_readback), 32'h0);

    // R2/R8: vector table of full loads
    for (int i = 0; i < 6; i++) begin
      load(int'(VECS[i][13:12]), VECS[i][11:0]);
      check_all("R2 table load");
    end
    // R8: 0x00A loaded into register 0 appears on obs_out
    check("R8 obs", 32'(obs_out), 32'h00A);

    // R3: index 0 hits bit 11, index 11 hits bit 0
    load(3, 12'h000);
    wr(cmd(1'b0, 1'b1, 3, 0));
    wr(cmd(1'b1, 1'b1, 3, 0));
    tick();
    check("R3 idx0->bit11", 32'(unlock_thresh), 32'h800);
    wr(cmd(1'b0, 1'b1, 3, 11));
    wr(cmd(1'b1, 1'b1, 3, 11));
    tick();
    model[3] = 12'h801;
    check("R3 idx11->bit0", 32'(unlock_thresh), 32'h801);

    // R7: latency. After the capture edge the output is unchanged; one edge later it shows.
    wr(cmd(1'b0, 1'b1, 1, 5));
    check("R6 readback", 32'(cmd_readback), 32'(cmd(1'b0, 1'b1, 1, 5)));
    load(1, 12'h000);
    wr(cmd(1'b0, 1'b1, 1, 5));
    wr(cmd(1'b1, 1'b1, 1, 5));
    check("R7 not yet", 32'(decay_step), 32'h000);
    tick();
    model[1] = 12'h040;
    check("R7 visible", 32'(decay_step), 32'h040);

    // R4: a strobe-set write after a strobe-set write has no effect
    wr(cmd(1'b1, 1'b0, 1, 5));
    wr(cmd(1'b1, 1'b1, 1, 0));
    tick();
    check_all("R4 held strobe");
    // R4: a strobe-clear write alone does not update
    wr(cmd(1'b0, 1'b0, 1, 5));
    tick();
    check_all("R4 strobe clear");

    // R5: indices 12..15 ignored
    for (int k = 12; k < 16; k++) begin
      wr(cmd(1'b0, 1'b1, 2, k));
      wr(cmd(1'b1, 1'b1, 2, k));
      tick();
    end
    check_all("R5 high index");

    // R9: bus activity without wr_en
    wr(cmd(1'b0, 1'b0, 0, 3));
    @(negedge clk);
    wr_byte = cmd(1'b1, 1'b1, 0, 3);
    repeat (3) tick();
    check("R9 readback", 32'(cmd_readback), 32'(cmd(1'b0, 1'b0, 0, 3)));
    check_all("R9 regs");

    // R1: mid-run reset
    @(negedge clk);
    rst = 1'b1;
    tick();
    rst = 1'b0;
    for (int r = 0; r < 4; r++) model[r] = '0;
    check_all("R1 mid reset");
    check("R1 readback mid", 32'(cmd_readback), 32'h0);

    // R4: the first strobe-set write after reset counts as a rise
    wr(cmd(1'b1, 1'b1, 0, 11));
    tick();
    model[0] = 12'h001;
    check_all("R4 first after reset");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule